// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial output line. A byte written on the bus lands in a one-character holding register. The block then moves it into a transmit shift register. On the way it wraps the byte in framing bits, and the bits leave at a rate set by a free-running oversampling tick. A ready flag tells software when the holding register can take the next byte. Software can therefore queue one character while another is still on the wire.

The next waiting byte is handed to the shift register halfway through the stop bit of the frame in flight. The line still finishes that stop bit, and the next start bit follows it with no idle time in between. When the transmitter is switched on, it first sends a frame of all ones so that a receiver can lock on. While it is switched off, the output pin carries a general-purpose output value in place of the transmitter.

Top module: `sci_tx_dbuf`

## Requirements
- R1: After reset the ready flag `hold_empty` is 1. With the transmitter enabled and nothing queued, `txd` rests at 1.
- R2: A write clears `hold_empty` on the next clock. A second write before the hand-off replaces the waiting byte, so only the last byte written is sent.
- R3: Each data frame is 10 bits: a start bit of 0, then the eight data bits least-significant first, then a stop bit of 1. Each bit lasts OVERSAMPLE ticks (16 by default), and `txd` changes only on a clock edge where `baud_tick` is sampled high.
- R4: When the line is idle and a byte is waiting, the transfer pulse occurs on the first tick edge after the write. The start bit begins on the next tick edge after the byte is loaded.
- R5: When a byte is waiting during a frame, its start bit begins on the same tick that ends the previous stop bit. No idle ticks come between the two frames.
- R6: When the holding register is empty at the end of a frame, no transfer occurs, `hold_empty` stays 1 and `txd` stays 1.
- R7: A rising edge of `tx_enable` arms a preamble. On the first tick after that edge the shifter loads ten 1 bits, and no data is handed off while the preamble is still armed. A byte already waiting has its start bit begin on the 10*OVERSAMPLE+2-th tick edge after the enable edge, counting the tick that loads the preamble as the first.
- R8: While `tx_enable` is 0, `txd` equals `gpio_out`, no transfer occurs, and a waiting byte is kept until the transmitter is enabled.
- R9: During a frame, the hand-off happens on the tick that falls OVERSAMPLE/2 ticks after the stop bit's first tick. `hold_empty` rises exactly one clock edge after that tick edge, which is one clock after the transfer pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for the data register |
| wr_data | input | DATA_W | Byte to transmit |
| tx_enable | input | 1 | Transmitter enable; when low the pin carries `gpio_out` |
| baud_tick | input | 1 | Free-running oversampling tick, one clock wide, at least two clocks apart |
| gpio_out | input | 1 | General-purpose output value for the pin while disabled |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Ready flag: holding register can take a byte |

## Verification
The checker checks the following on every cycle. Every rise of the ready flag must be caused by a transfer pulse one clock earlier, and every pulse must follow a tick. Writes clear the flag. The line may move only on tick edges. Disabling the transmitter must freeze the waiting byte, and no hand-off may happen while a preamble is armed. The bench scenarios show the rest. They cover the bit order and the value of every byte, the exact tick on which a start bit begins after idle, after a preamble and after a back-to-back hand-off, and the exact edge on which the flag rises relative to the middle of the stop bit. They also check that an overwritten byte never appears on the line.

// File: rtl/sci_tx_pkg.sv
// Shared types for the double-buffered serial transmitter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sci_tx_pkg;

    // Activity of the bit shifter: resting high, or inside a frame.
    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_BUSY = 1'b1
    } tx_mode_e;

endpackage

// File: rtl/sci_tx_hold.sv
// Holding register in front of the shifter. It stores one byte and the
// ready flag. A write loads the byte and clears the flag. A transfer pulse
// sets the flag one edge later. A write in the same cycle wins, so a fresh
// byte is never marked as taken.
// Assumes: xfer is a single-cycle pulse.
module sci_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty
);

    logic [DATA_W-1:0] data_q;
    logic              empty_q;

    // Purpose: capture written bytes and track whether the buffer is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            empty_q <= 1'b1;
        end else if (wr_en) begin
            data_q  <= wr_data;
            empty_q <= 1'b0;
        end else if (xfer) begin
            empty_q <= 1'b1;
        end
    end

    assign hold_data  = data_q;
    assign hold_empty = empty_q;

endmodule

// File: rtl/sci_tx_sched.sv
// Transfer scheduler. It detects the enable edge, arms the preamble, and
// decides on which tick a waiting byte may enter the shifter. The hand-off
// is registered, so the pulse appears on the edge after the tick edge.
// Assumes: baud_tick pulses are one clock wide and at least two clocks apart.
module sci_tx_sched (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic hold_empty,
    input  logic idle_ready,
    input  logic last_mid,
    output logic xfer,
    output logic pre_load,
    output logic pre_pending
);

    logic en_q;
    logic pre_q;
    logic xfer_q;
    logic en_rise;
    logic want_xfer;

    assign en_rise   = enable & ~en_q;
    assign pre_load  = enable & tick & pre_q & idle_ready;
    assign want_xfer = enable & tick & ~hold_empty & ~pre_q & ~en_rise
                     & (idle_ready | last_mid);

    // Purpose: remember the enable level, the armed preamble and the pending pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pre_q  <= 1'b0;
            xfer_q <= 1'b0;
        end else begin
            en_q   <= enable;
            xfer_q <= want_xfer;
            if (!enable) begin
                pre_q <= 1'b0;
            end else if (en_rise) begin
                pre_q <= 1'b1;
            end else if (pre_load) begin
                pre_q <= 1'b0;
            end
        end
    end

    assign xfer        = xfer_q & enable;
    assign pre_pending = pre_q;

endmodule

// File: rtl/sci_tx_shifter.sv
// Bit shifter with the oversampling bit timer. The current bit sits in a
// line register, and the bits still to go sit in a shift register. A new
// frame can therefore be loaded while the last bit of the old one is
// still on the line. A bit boundary takes the next bit from the shift
// register. With none left, the line returns to rest.
// Assumes: load never coincides with a tick that crosses a bit boundary.
module sci_tx_shifter #(
    parameter int FRAME_W    = 10,
    parameter int OVERSAMPLE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    output logic               line,
    output logic               idle_ready,
    output logic               last_mid
);
    import sci_tx_pkg::*;

    localparam int SUB_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int MID   = OVERSAMPLE / 2;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(MID - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    tx_mode_e           mode_q;
    logic [SUB_W-1:0]   sub_q;
    logic [CNT_W-1:0]   left_q;
    logic [FRAME_W-1:0] shift_q;
    logic               line_q;
    logic               at_edge;

    assign at_edge = tick && ((mode_q == MODE_BUSY && sub_q == SUB_LAST) ||
                              (mode_q == MODE_IDLE && left_q != '0));

    // Purpose: advance the bit timer, step bits onto the line, accept loads.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            mode_q  <= MODE_IDLE;
            sub_q   <= '0;
            left_q  <= '0;
            shift_q <= '1;
            line_q  <= 1'b1;
        end else begin
            if (at_edge) begin
                sub_q <= '0;
                if (left_q != '0) begin
                    line_q  <= shift_q[0];
                    shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                    left_q  <= left_q - CNT_W'(1);
                    mode_q  <= MODE_BUSY;
                end else begin
                    line_q <= 1'b1;
                    mode_q <= MODE_IDLE;
                end
            end else if (tick && mode_q == MODE_BUSY) begin
                sub_q <= sub_q + SUB_W'(1);
            end
            if (load) begin
                shift_q <= load_frame;
                left_q  <= CNT_FULL;
            end
        end
    end

    assign line       = line_q;
    assign idle_ready = (mode_q == MODE_IDLE) && (left_q == '0);
    assign last_mid   = (mode_q == MODE_BUSY) && (left_q == '0) && (sub_q == SUB_MID);

endmodule

// File: rtl/sci_tx_dbuf.sv
// Top of the double-buffered serial transmitter. It joins the holding
// register, the transfer scheduler and the bit shifter, and selects the
// pin source. A preamble load or a data hand-off chooses the frame that
// enters the shifter.
// Assumes: baud_tick is one clock wide with at least two clocks between pulses.
module sci_tx_dbuf #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic              baud_tick,
    input  logic              gpio_out,
    output logic              txd,
    output logic              hold_empty
);

    localparam int FRAME_W = DATA_W + 2;

    logic [DATA_W-1:0]  hold_data_w;
    logic               hold_empty_w;
    logic               xfer_w;
    logic               pre_load_w;
    logic               pre_pending_w;
    logic               idle_ready_w;
    logic               last_mid_w;
    logic               line_w;
    logic               load_w;
    logic [FRAME_W-1:0] frame_w;

    sci_tx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .xfer       (xfer_w),
        .hold_data  (hold_data_w),
        .hold_empty (hold_empty_w)
    );

    sci_tx_sched sched_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (tx_enable),
        .tick        (baud_tick),
        .hold_empty  (hold_empty_w),
        .idle_ready  (idle_ready_w),
        .last_mid    (last_mid_w),
        .xfer        (xfer_w),
        .pre_load    (pre_load_w),
        .pre_pending (pre_pending_w)
    );

    // Purpose: choose the all-ones preamble or a framed data byte.
    always_comb begin
        if (pre_load_w) begin
            frame_w = '1;
        end else begin
            frame_w = {1'b1, hold_data_w, 1'b0};
        end
    end

    assign load_w = pre_load_w | xfer_w;

    sci_tx_shifter #(.FRAME_W(FRAME_W), .OVERSAMPLE(OVERSAMPLE)) shift_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_enable),
        .tick       (baud_tick),
        .load       (load_w),
        .load_frame (frame_w),
        .line       (line_w),
        .idle_ready (idle_ready_w),
        .last_mid   (last_mid_w)
    );

    assign txd        = tx_enable ? line_w : gpio_out;
    assign hold_empty = hold_empty_w;

endmodule

// File: rtl/sci_tx_chk.sv
// Property checker for the serial transmitter. It is bound to the top and
// watches the ports together with the pulses passed between the scheduler
// and the holding register.
module sci_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic tx_enable,
    input logic baud_tick,
    input logic txd,
    input logic hold_empty,
    input logic xfer,
    input logic pre_pending
);

    assert_wr_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    assert_line_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && $past(tx_enable) && (txd != $past(txd))) |-> $past(baud_tick));

    assert_xfer_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> $past(baud_tick));

    assert_no_xfer_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pre_pending |-> !xfer);

    assert_enable_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |=> pre_pending);

    assert_disabled_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !wr_en && !hold_empty) |=> !hold_empty);

    assert_flag_after_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wr_en) |=> hold_empty);

    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> $past(xfer));

endmodule

bind sci_tx_dbuf sci_tx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .tx_enable   (tx_enable),
    .baud_tick   (baud_tick),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .xfer        (xfer_w),
    .pre_pending (pre_pending_w)
);

// File: tb/sci_tx_dbuf_tb.sv
// Bench for the serial transmitter. It uses OVERSAMPLE=4 with a tick on
// every even clock edge. It decodes every frame from the line and sweeps
// all 256 byte values back to back.
module sci_tx_dbuf_tb_top;

    localparam int DW = 8;
    localparam int OS = 4;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          tx_enable = 1'b0;
    logic          baud_tick = 1'b0;
    logic          gpio_out = 1'b0;
    logic          txd;
    logic          hold_empty;

    sci_tx_dbuf #(.DATA_W(DW), .OVERSAMPLE(OS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_enable  (tx_enable),
        .baud_tick  (baud_tick),
        .gpio_out   (gpio_out),
        .txd        (txd),
        .hold_empty (hold_empty)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Line monitor state
    bit            tick_run = 1'b0;
    bit            in_frame = 1'b0;
    int            j = 0;
    logic [DW-1:0] acc = '0;
    bit            bad = 1'b0;
    logic          bit_first = 1'b1;
    int            hi_run = 0;
    int            frames_done = 0;
    int            mid_edge = 0;
    int            start_edge = 0;
    int            flag_edge = 0;
    logic          prev_flag = 1'b1;
    bit            gap_chk = 1'b0;
    int            gap_from = 0;
    bit            flag_chk = 1'b0;
    logic [DW-1:0] exp_q[$];

    task automatic mon_sample(input logic s);
        int b;
        logic [DW-1:0] e;
        if (!in_frame) begin
            if (s === 1'b0) begin
                if (gap_chk && frames_done >= gap_from)
                    check(hi_run == 0, "R5 idle ticks between frames", hi_run, 0);
                in_frame   = 1'b1;
                j          = 0;
                acc        = '0;
                bad        = 1'b0;
                start_edge = cyc;
            end else begin
                hi_run++;
            end
        end
        if (in_frame) begin
            if (j % OS == 0) bit_first = s;
            else if (s !== bit_first) bad = 1'b1;
            if (j % OS == OS / 2) begin
                b = j / OS;
                if (b == 0 && s !== 1'b0) bad = 1'b1;
                else if (b == FW - 1 && s !== 1'b1) bad = 1'b1;
                else if (b >= 1 && b <= DW) acc[b-1] = s;
            end
            if (j == FW * OS - OS / 2) mid_edge = cyc;
            j++;
            if (j == FW * OS) begin
                in_frame = 1'b0;
                hi_run   = 0;
                frames_done++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected frame", int'(acc), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(!bad && acc == e, "R3 frame content", bad ? -1 : int'(acc), int'(e));
                end
            end
        end
    endtask

    // Purpose: sample the line after each tick edge, watch the flag, drive the next tick.
    always @(negedge clk) begin
        if (baud_tick) begin
            if (tx_enable) mon_sample(txd);
        end
        if (!tx_enable) begin
            in_frame = 1'b0;
            hi_run   = 0;
        end
        if (rst_n && hold_empty && !prev_flag) begin
            flag_edge = cyc;
            if (flag_chk && in_frame)
                check(cyc == mid_edge + 1, "R9 flag edge after mid-stop tick", cyc, mid_edge + 1);
        end
        prev_flag = hold_empty;
        baud_tick = tick_run && (cyc % 2 == 1);
    end

    // Purpose: end a hung run as a failure.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic write_byte(input logic [DW-1:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    initial begin
        int e0;
        int t1;
        int w;
        int base;
        bit ok;

        // R1: reset state
        repeat (4) @(negedge clk);
        check(hold_empty === 1'b1, "R1 flag after reset", int'(hold_empty), 1);
        gpio_out = 1'b0;
        @(negedge clk);
        check(txd === 1'b0, "R8 pin follows gpio 0 in reset", int'(txd), 0);
        gpio_out = 1'b1;
        @(negedge clk);
        check(txd === 1'b1, "R8 pin follows gpio 1 in reset", int'(txd), 1);
        rst_n    = 1'b1;
        tick_run = 1'b1;
        repeat (4) @(negedge clk);

        // R8 and R2: write while disabled, byte is held, pin follows gpio
        write_byte(8'hA5);
        check(hold_empty === 1'b0, "R2 write clears flag", int'(hold_empty), 0);
        ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            gpio_out = k[0];
            @(negedge clk);
            if (txd !== gpio_out || hold_empty !== 1'b0) ok = 1'b0;
        end
        check(ok, "R8 disabled pin and held byte", int'(txd), int'(gpio_out));

        // R7: enable sends preamble, then the waiting byte
        gpio_out = 1'b1;
        exp_q.push_back(8'hA5);
        e0 = cyc + 1;
        tx_enable = 1'b1;
        t1 = (e0 % 2 == 0) ? e0 + 2 : e0 + 1;
        while (frames_done < 1) @(negedge clk);
        check(start_edge == t1 + 2 * (FW * OS + 1), "R7 start after preamble",
              start_edge, t1 + 2 * (FW * OS + 1));

        // R6 and R1: nothing queued, line rests high, flag stays set
        ok = 1'b1;
        for (int k = 0; k < 6 * OS; k++) begin
            @(negedge clk);
            if (txd !== 1'b1 || hold_empty !== 1'b1) ok = 1'b0;
        end
        check(ok && frames_done == 1, "R6 idle after frame", frames_done, 1);
        check(txd === 1'b1, "R1 enabled idle line", int'(txd), 1);

        // R4: idle hand-off timing
        exp_q.push_back(8'h3C);
        w  = cyc + 1;
        t1 = (w % 2 == 0) ? w + 2 : w + 1;
        write_byte(8'h3C);
        while (frames_done < 2) @(negedge clk);
        check(flag_edge == t1 + 1, "R4 flag edge after idle hand-off", flag_edge, t1 + 1);
        check(start_edge == t1 + 2, "R4 start edge after idle hand-off", start_edge, t1 + 2);

        // R2: overwrite of a waiting byte
        exp_q.push_back(8'hEE);
        wr_en   = 1'b1;
        wr_data = 8'h11;
        @(negedge clk);
        wr_data = 8'hEE;
        @(negedge clk);
        wr_en   = 1'b0;
        check(hold_empty === 1'b0 || frames_done == 2, "R2 flag low after writes", int'(hold_empty), 0);
        while (frames_done < 3) @(negedge clk);
        repeat (4 * FW * OS) @(negedge clk);
        check(frames_done == 3 && exp_q.size() == 0, "R2 only last byte sent", frames_done, 3);

        // R5 and R9: all byte values back to back
        base     = frames_done;
        gap_from = base + 1;
        gap_chk  = 1'b1;
        for (int k = 0; k < 256; k++) begin
            while (hold_empty !== 1'b1) @(negedge clk);
            exp_q.push_back(k[7:0]);
            write_byte(k[7:0]);
            if (k == 0) flag_chk = 1'b1;
        end
        while (frames_done < base + 256) @(negedge clk);
        gap_chk  = 1'b0;
        flag_chk = 1'b0;
        check(exp_q.size() == 0, "R3 all sweep frames received", exp_q.size(), 0);

        // R8: disabling mid-frame hands the pin back to gpio
        write_byte(8'h5A);
        while (!in_frame) @(negedge clk);
        repeat (3) @(negedge clk);
        gpio_out  = 1'b0;
        tx_enable = 1'b0;
        @(negedge clk);
        check(txd === 1'b0, "R8 pin follows gpio after disable", int'(txd), 0);
        gpio_out = 1'b1;
        @(negedge clk);
        check(txd === 1'b1, "R8 pin follows gpio toggle", int'(txd), 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule